// File: doc/BRIEF.md
# Prescaled Frame PWM Channel

This block drives one pulse-width-modulated output from a single 32-bit control word. The word carries an enable flag, a clock-division value and a duty value. A prescaler turns the input clock into step ticks, one every *divisor* cycles. An 8-bit phase counter advances on each tick and walks through a 256-step frame. Every frame starts low and goes high once the phase reaches the duty value, so the duty value sets the length of the low part of the frame, not the high part.

Software writes the control word through a plain write/read port. While the channel runs, a new word is staged and takes effect only at the next frame boundary, so no frame mixes old and new settings. Clearing the enable flag or writing a duty of zero stops the channel. The output is then forced low and both counters are held at zero.

Top module: `stepped_pwm`

## Requirements
- R1: A write stores all 32 bits of the control word, and reads return the last value written. After reset the word reads as zero.
- R2: Bit 31 is the enable flag, bits 15:8 hold the division value and bits 7:0 hold the duty value. Bits 30:16 are stored but do not change the output waveform.
- R3: A division value N from 1 to 255 produces one step tick every N clock cycles. A division value of 0 produces one step tick every 256 cycles.
- R4: For a duty value D from 1 to 255, each frame lasts 256 steps. The output is low for the first D steps and high for the remaining 256−D steps, so one period is 256 × divisor cycles.
- R5: With duty value 0, the output stays low permanently. The prescaler and phase counter are held at zero.
- R6: The first frame starts on the second rising edge after the enabling write. The output is therefore low for D × divisor + 1 cycles, counted from the enabling write edge.
- R7: A new division or duty value written while the channel runs is used only from the next frame boundary onward. The current frame completes with the old settings.
- R8: Clearing the enable flag forces the output low in the cycle that follows the write edge, and the counters restart from zero.
- R9: Reset is synchronous and active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to store |
| rd_data | output | 32 | Stored control word |
| pwm_out | output | 1 | PWM output |

## Verification
A wrong prescaler count or phase wrap changes the measured low and high lengths of the very first frame after enabling. The bench compares those lengths to the exact cycle counts computed from D and the divisor. If the staged settings are applied early or late, the low length of the frame in progress and the shape of the following frame both come out wrong, so the error is visible within two frames. A failure to clear the counters on disable, or to force the output low, shows up one cycle after the clearing write, or as a shifted first frame on the next enable.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

   // Decoded operating state of the channel
   typedef enum logic {
      CH_IDLE = 1'b0,
      CH_RUN  = 1'b1
   } ch_state_e;

   // Number of clock cycles per step for a division field (zero means 2**w)
   function automatic int unsigned step_cycles(input int unsigned field, input int unsigned w);
      return (field == 0) ? (1 << w) : field;
   endfunction

endpackage

// File: rtl/spwm_ctrl_reg.sv
module spwm_ctrl_reg #(
   parameter int REG_W      = 32,
   parameter int EN_POS     = 31,
   parameter int DIV_LSB    = 8,
   parameter int DIV_W      = 8,
   parameter int DUTY_LSB   = 0,
   parameter int DUTY_W     = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              load_act,
   output logic [REG_W-1:0]  word,
   output logic              en_live,
   output logic [DIV_W-1:0]  div_live,
   output logic [DUTY_W-1:0] duty_live,
   output logic [DIV_W-1:0]  div_act,
   output logic [DUTY_W-1:0] duty_act
);

   localparam int DIV_MSB  = DIV_LSB + DIV_W - 1;
   localparam int DUTY_MSB = DUTY_LSB + DUTY_W - 1;

   initial begin
      assert (EN_POS < REG_W) else $error("enable bit outside word");
      assert (DIV_MSB < REG_W && DUTY_MSB < REG_W) else $error("field outside word");
      assert (DUTY_MSB < DIV_LSB || DIV_MSB < DUTY_LSB) else $error("fields overlap");
   end

   always_ff @(posedge clk) begin
      if (rst)        word <= '0;
      else if (wr_en) word <= wr_data;
   end

   assign en_live   = word[EN_POS];
   assign div_live  = word[DIV_MSB:DIV_LSB];
   assign duty_live = word[DUTY_MSB:DUTY_LSB];

   // Staged copy used by the counters; refreshed when idle or at a frame end
   always_ff @(posedge clk) begin
      if (rst) begin
         div_act  <= '0;
         duty_act <= '0;
      end else if (load_act) begin
         div_act  <= div_live;
         duty_act <= duty_live;
      end
   end

   // R7: staged settings change only when a load is requested
   a_r7_stage_hold: assert property (@(posedge clk) disable iff (rst)
      !load_act |=> ($stable(div_act) && $stable(duty_act)));

endmodule

// File: rtl/spwm_prescaler.sv
module spwm_prescaler #(
   parameter int DIV_W       = 8,
   parameter bit ZERO_IS_MAX = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic [DIV_W-1:0] div_act,
   output logic             tick
);

   initial begin
      assert (DIV_W >= 1 && DIV_W <= 16) else $error("DIV_W out of range");
   end

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] last;

   generate
      if (ZERO_IS_MAX) begin : g_zero_max
         // 0 - 1 wraps to all ones: divide by 2**DIV_W
         assign last = div_act - 1'b1;
      end else begin : g_zero_one
         assign last = (div_act == '0) ? '0 : div_act - 1'b1;
      end
   endgenerate

   assign tick = run && (cnt == last);

   always_ff @(posedge clk) begin
      if (rst || !run)  cnt <= '0;
      else if (tick)    cnt <= '0;
      else              cnt <= cnt + 1'b1;
   end

   // R3: between ticks the count advances by one each cycle
   a_r3_count_up: assert property (@(posedge clk) disable iff (rst)
      (run && !tick) |=> (cnt == $past(cnt) + 1'b1));

   // R5: idle holds the prescaler at zero
   a_r5_presc_idle: assert property (@(posedge clk) disable iff (rst)
      !run |=> (cnt == '0));

endmodule

// File: rtl/spwm_frame.sv
module spwm_frame #(
   parameter int STEP_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              run,
   input  logic              tick,
   input  logic [STEP_W-1:0] duty_act,
   output logic [STEP_W-1:0] phase,
   output logic              frame_end,
   output logic              level
);

   localparam logic [STEP_W-1:0] LAST_STEP = {STEP_W{1'b1}};

   initial begin
      assert (STEP_W >= 2 && STEP_W <= 16) else $error("STEP_W out of range");
   end

   always_ff @(posedge clk) begin
      if (rst || !run) phase <= '0;
      else if (tick)   phase <= phase + 1'b1;
   end

   assign frame_end = tick && (phase == LAST_STEP);
   assign level     = (phase >= duty_act);

   // R4: the last step of a frame wraps the phase back to zero
   a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
      (run && tick && phase == LAST_STEP) |=> (phase == '0));

   // R5: idle holds the phase at zero
   a_r5_phase_idle: assert property (@(posedge clk) disable iff (rst)
      !run |=> (phase == '0));

endmodule

// File: rtl/stepped_pwm.sv
module stepped_pwm #(
   parameter int REG_W       = 32,
   parameter int EN_POS      = 31,
   parameter int DIV_LSB     = 8,
   parameter int DIV_W       = 8,
   parameter int DUTY_LSB    = 0,
   parameter int STEP_W      = 8,
   parameter bit ZERO_IS_MAX = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             pwm_out
);
   import spwm_pkg::*;

   logic              en_live;
   logic [DIV_W-1:0]  div_live;
   logic [STEP_W-1:0] duty_live;
   logic [DIV_W-1:0]  div_act;
   logic [STEP_W-1:0] duty_act;
   logic              load_act;
   logic              tick;
   logic [STEP_W-1:0] phase;
   logic              frame_end;
   logic              level;
   logic              run_live;
   ch_state_e         state;
   logic              run_q;

   assign run_live = en_live && (duty_live != '0);

   always_ff @(posedge clk) begin
      if (rst) state <= CH_IDLE;
      else     state <= run_live ? CH_RUN : CH_IDLE;
   end

   assign run_q    = (state == CH_RUN);
   assign load_act = !run_q || frame_end;

   spwm_ctrl_reg #(
      .REG_W(REG_W), .EN_POS(EN_POS), .DIV_LSB(DIV_LSB), .DIV_W(DIV_W),
      .DUTY_LSB(DUTY_LSB), .DUTY_W(STEP_W)
   ) i_reg (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .load_act(load_act), .word(rd_data), .en_live(en_live),
      .div_live(div_live), .duty_live(duty_live),
      .div_act(div_act), .duty_act(duty_act)
   );

   spwm_prescaler #(.DIV_W(DIV_W), .ZERO_IS_MAX(ZERO_IS_MAX)) i_presc (
      .clk(clk), .rst(rst), .run(run_q), .div_act(div_act), .tick(tick)
   );

   spwm_frame #(.STEP_W(STEP_W)) i_frame (
      .clk(clk), .rst(rst), .run(run_q), .tick(tick), .duty_act(duty_act),
      .phase(phase), .frame_end(frame_end), .level(level)
   );

   assign pwm_out = run_live && run_q && level;

   // R4: the output rises exactly when the phase meets the staged duty value
   a_r4_rise_at_duty: assert property (@(posedge clk) disable iff (rst)
      $rose(pwm_out) |-> (phase == duty_act));

   // R6: a fresh start begins its frame at phase zero with the output low
   a_r6_start_low: assert property (@(posedge clk) disable iff (rst)
      $rose(run_q) |-> (!pwm_out && phase == '0));

endmodule

// File: tb/test_stepped_pwm.sv
`timescale 1ns/1ps
module test_stepped_pwm;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        pwm_out;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   stepped_pwm i_stepped_pwm (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .pwm_out(pwm_out)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // called at a negedge; the write lands on the next rising edge; returns at the following negedge
   task automatic wr(input logic [31:0] v);
      wr_en   = 1'b1;
      wr_data = v;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic run_len(input logic lvl, output int n);
      n = 0;
      while (pwm_out == lvl && n < 70000) begin
         n++;
         @(negedge clk);
      end
   endtask

   function automatic logic [31:0] word(input logic en, input int dv, input int dt);
      return {en, 15'h0, dv[7:0], dt[7:0]};
   endfunction

   // R3 R4 R6: first low run and first high run after a fresh enable
   task automatic one_case(input int dv, input int dt, input logic [31:0] extra);
      int lo, hi, dvr;
      dvr = (dv == 0) ? 256 : dv;
      wr(32'h0);
      repeat (2) @(negedge clk);
      wr(word(1'b1, dv, dt) | extra);
      run_len(1'b0, lo);
      run_len(1'b1, hi);
      check($sformatf("R4/R6 low div%0d duty%0d", dvr, dt), lo, dt * dvr + 1);
      check($sformatf("R3/R4 high div%0d duty%0d", dvr, dt), hi, (256 - dt) * dvr);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      int lo, hi, z;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R9 R1: reset state
      check("R9 reset word", rd_data, 0);
      check("R9 reset output", pwm_out, 0);

      // R1: readback of every bit
      wr(32'h7FFF_A5C3);
      check("R1 readback", rd_data, 32'h7FFF_A5C3);
      wr(32'h0);
      check("R1 readback zero", rd_data, 0);

      // R2: bits 30:16 set on one run, no effect on timing
      one_case(1, 1, 32'h7FFF_0000);
      one_case(1, 8'h80, 32'h0);
      one_case(1, 8'hFF, 32'h0);
      one_case(2, 1, 32'h0);
      one_case(2, 8'h80, 32'h5A5A_0000);
      one_case(2, 8'hFF, 32'h0);
      one_case(3, 1, 32'h0);
      one_case(0, 8'h80, 32'h0);
      one_case(0, 8'hFF, 32'h0);

      // R5: duty 0 with enable set stays low
      wr(32'h0);
      repeat (2) @(negedge clk);
      wr(word(1'b1, 1, 0));
      z = 0;
      for (int i = 0; i < 600; i++) begin
         if (pwm_out) z++;
         @(negedge clk);
      end
      check("R5 duty zero high cycles", z, 0);

      // R8: clearing enable while high
      wr(32'h0);
      repeat (2) @(negedge clk);
      wr(word(1'b1, 1, 2));
      run_len(1'b0, lo);
      check("R8 pre high", pwm_out, 1);
      wr(32'h0);
      check("R8 low after disable", pwm_out, 0);
      z = 0;
      for (int i = 0; i < 300; i++) begin
         if (pwm_out) z++;
         @(negedge clk);
      end
      check("R8 stays low", z, 0);
      // R8: counters restarted, next enable gives a clean first frame
      one_case(1, 8'h40, 32'h0);

      // R7: mid-frame change of divisor and duty waits for the boundary
      wr(32'h0);
      repeat (2) @(negedge clk);
      wr(word(1'b1, 1, 8'h80));
      repeat (20) @(negedge clk);
      wr(word(1'b1, 2, 8'h40));
      run_len(1'b0, lo);
      check("R7 remaining low old settings", lo, 108);
      run_len(1'b1, hi);
      check("R7 high old settings", hi, 128);
      run_len(1'b0, lo);
      check("R7 low new settings", lo, 128);
      run_len(1'b1, hi);
      check("R7 high new settings", hi, 384);

      wr(32'h0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule